// File: doc/BRIEF.md
# Serial Register-Write Control Port

This block is a write-only serial control port for a small register file, such as the configuration registers of an audio converter. Three serial inputs come from an external host: a chip-select (active low), a serial clock and a serial data line. All three are oversampled in the system clock domain. After a chip-select falling edge, the port takes in bytes most significant bit first. The first byte must carry the fixed chip identifier. The second byte selects a register. Each byte after that is written into the register file.

A steering bit in register 0 decides what happens after a data byte. When the bit is set, the pointer steps forward after every data byte, so one frame can fill several neighbouring registers. When the bit is clear, each frame writes a single register. The port stays inert until it has seen a chip-select falling edge after reset. The core reads every register in parallel. It also receives a one-cycle strobe for each completed write, carrying the index and the data.

Top module: `spi_regport`

## Requirements
- R1: After reset all registers read 0, and `mode_latched`, `addr_err` and `wr_stb` are 0.
- R2: `mode_latched` rises on the first high-to-low transition of `ser_csn` after reset and stays set. A frame sent while `ser_csn` has been low since reset, with no falling edge, writes nothing.
- R3: Data is taken from `ser_dat` on rising edges of `ser_clk` while `ser_csn` is low, and bytes are assembled most significant bit first.
- R4: The first byte of a frame must equal 8'h20. Any other value sets `addr_err` and causes the rest of the frame to be ignored. `addr_err` clears on the next `ser_csn` falling edge.
- R5: The second byte of a frame is the register pointer. Only its low 3 bits are used.
- R6: Each accepted data byte produces a one-cycle `wr_stb` with `wr_idx` equal to the pointer and `wr_data` equal to the byte. The register holds that value from the following cycle on.
- R7: If bit 7 of register 0 is 1 before a data byte is written, the pointer advances by one after that byte. The step from register 7 wraps to register 0.
- R8: If bit 7 of register 0 is 0 before a data byte is written, that byte is written and every later byte in the same frame is ignored.
- R9: Raising `ser_csn` in the middle of a byte discards the partial byte and returns the port to expecting a chip byte. Registers written earlier keep their values.
- R10: No register changes in a cycle that does not follow a `wr_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dat | input | 1 | Serial data from the host |
| ser_csn | input | 1 | Chip select, active low |
| mode_latched | output | 1 | Sticky flag: the serial port has been enabled |
| addr_err | output | 1 | The chip byte of the current frame did not match |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_idx | output | 3 | Index of the register being written |
| wr_data | output | 8 | Value being written |
| reg_flat | output | 64 | All registers; register k occupies bits [8k+7:8k] |

## Verification
Two things can coincide on a single data byte: the write into register 0 and the decision on whether the pointer advances. That decision depends on register 0's steering bit. The bench provokes this with an incrementing burst that wraps from register 7 into register 0 and clears the steering bit there. The expected result is that the clearing byte still advances the pointer, because the decision uses the value held before the write. The next byte lands in register 1, and the byte after it is dropped. The reference model applies the same rule byte by byte, and every strobe is compared with the model's queue of expected writes.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  typedef enum logic [1:0] {
    RX_CHIP = 2'd0,
    RX_PTR  = 2'd1,
    RX_DATA = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_t;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
  assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/spi_regport_rx.sv
module spi_regport_rx
  import spi_regport_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          PTR_W   = 3,
  parameter logic [7:0]  CHIP_ID = 8'h20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_rise,
  input  logic             sdat,
  input  logic             cs_active,
  input  logic             cs_fall,
  input  logic             mode_on,
  input  logic             auto_inc,
  output logic             we,
  output logic [PTR_W-1:0] widx,
  output logic [DW-1:0]    wdat,
  output logic             addr_err
);
  localparam int BC_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DW - 1);

  rx_state_t        state;
  logic [DW-1:0]    shreg;
  logic [BC_W-1:0]  bitcnt;
  logic [PTR_W-1:0] ptr;
  logic [DW-1:0]    byte_in;

  assign byte_in = {shreg[DW-2:0], sdat};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_CHIP;
      shreg    <= '0;
      bitcnt   <= '0;
      ptr      <= '0;
      we       <= 1'b0;
      widx     <= '0;
      wdat     <= '0;
      addr_err <= 1'b0;
    end else begin
      we <= 1'b0;
      if (cs_fall) addr_err <= 1'b0;
      if (!cs_active) begin
        bitcnt <= '0;
        state  <= RX_CHIP;
      end else if (mode_on && sclk_rise) begin
        shreg  <= byte_in;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == LAST_BIT) begin
          bitcnt <= '0;
          unique case (state)
            RX_CHIP: begin
              if (byte_in[7:0] == CHIP_ID) begin
                state <= RX_PTR;
              end else begin
                state    <= RX_SKIP;
                addr_err <= 1'b1;
              end
            end
            RX_PTR: begin
              ptr   <= byte_in[PTR_W-1:0];
              state <= RX_DATA;
            end
            RX_DATA: begin
              we   <= 1'b1;
              widx <= ptr;
              wdat <= byte_in;
              if (auto_inc) ptr   <= ptr + 1'b1;
              else          state <= RX_SKIP;
            end
            default: state <= RX_SKIP;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_regport_regfile.sv
module spi_regport_regfile #(
  parameter int REG_CNT = 8,
  parameter int DW      = 8,
  parameter int PTR_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [PTR_W-1:0]      widx,
  input  logic [DW-1:0]         wdat,
  output logic [REG_CNT*DW-1:0] flat
);
  logic [DW-1:0] mem [REG_CNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_CNT; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdat;
    end
  end

  generate
    for (genvar g = 0; g < REG_CNT; g++) begin : g_out
      assign flat[g*DW +: DW] = mem[g];
    end
  endgenerate
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int         REG_CNT     = 8,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         AINC_BIT    = 7,
  parameter logic [7:0] CHIP_ID     = 8'h20,
  localparam int        PTR_W       = $clog2(REG_CNT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_clk,
  input  logic                  ser_dat,
  input  logic                  ser_csn,
  output logic                  mode_latched,
  output logic                  addr_err,
  output logic                  wr_stb,
  output logic [PTR_W-1:0]      wr_idx,
  output logic [DW-1:0]         wr_data,
  output logic [REG_CNT*DW-1:0] reg_flat
);
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic dat_lvl, dat_rise, dat_fall;
  logic csn_lvl, csn_rise, csn_fall;
  logic mode_q;

  spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst(rst), .din(ser_clk),
    .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));

  spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst(rst), .din(ser_dat),
    .level(dat_lvl), .rise(dat_rise), .fall(dat_fall));

  spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync_csn (
    .clk(clk), .rst(rst), .din(ser_csn),
    .level(csn_lvl), .rise(csn_rise), .fall(csn_fall));

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= 1'b0;
    else if (csn_fall) mode_q <= 1'b1;
  end

  spi_regport_rx #(.DW(DW), .PTR_W(PTR_W), .CHIP_ID(CHIP_ID)) u_rx (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .sdat(dat_lvl),
    .cs_active(~csn_lvl), .cs_fall(csn_fall),
    .mode_on(mode_q), .auto_inc(reg_flat[AINC_BIT]),
    .we(wr_stb), .widx(wr_idx), .wdat(wr_data), .addr_err(addr_err));

  spi_regport_regfile #(.REG_CNT(REG_CNT), .DW(DW), .PTR_W(PTR_W)) u_rf (
    .clk(clk), .rst(rst), .we(wr_stb), .widx(wr_idx), .wdat(wr_data),
    .flat(reg_flat));

  assign mode_latched = mode_q;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int REG_CNT = 8,
  parameter int DW      = 8,
  localparam int PTR_W  = $clog2(REG_CNT)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  mode_latched,
  input logic                  wr_stb,
  input logic [PTR_W-1:0]      wr_idx,
  input logic [DW-1:0]         wr_data,
  input logic [REG_CNT*DW-1:0] reg_flat
);
  logic [PTR_W-1:0] idx_q;
  logic [DW-1:0]    dat_q;

  always_ff @(posedge clk) begin
    idx_q <= wr_idx;
    dat_q <= wr_data;
  end

  // R2
  mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    mode_latched |=> mode_latched);

  // R2
  stb_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> mode_latched);

  // R6
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R6
  reg_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (reg_flat[int'(idx_q)*DW +: DW] == dat_q));

  // R10
  reg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(reg_flat));
endmodule

bind spi_regport spi_regport_chk #(.REG_CNT(REG_CNT), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mode_latched(mode_latched), .wr_stb(wr_stb),
  .wr_idx(wr_idx), .wr_data(wr_data), .reg_flat(reg_flat));

// File: tb/spi_regport_test.sv
module spi_regport_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        ser_csn = 1'b0;
  logic        mode_latched, addr_err, wr_stb;
  logic [2:0]  wr_idx;
  logic [7:0]  wr_data;
  logic [63:0] reg_flat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0]  mreg [8];
  bit          mmode = 0;
  logic [10:0] expq [$];

  always #10 clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_csn(ser_csn), .mode_latched(mode_latched), .addr_err(addr_err),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data), .reg_flat(reg_flat));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every clock: strobes compared with the model's expected write queue (R6, R8)
  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      if (expq.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", {wr_idx, wr_data}, 0);
      end else begin
        logic [10:0] e;
        e = expq.pop_front();
        check({wr_idx, wr_data} == e, "R6 strobe idx/data", {wr_idx, wr_data}, e);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    ser_clk = 1'b0;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  // behavioural model of one frame; bytes[] sent in order
  task automatic run_frame(input logic [7:0] bytes [$], input int partial_bits, input bit toggle_cs);
    int st = 0;
    int p = 0;
    if (toggle_cs) begin
      ser_csn = 1'b0;
      mmode = 1;
      wait_clk(6);
    end
    foreach (bytes[k]) begin
      if (mmode) begin
        case (st)
          0: st = (bytes[k] == 8'h20) ? 1 : 3;
          1: begin p = bytes[k][2:0]; st = 2; end
          2: begin
            bit inc = mreg[0][7];
            expq.push_back({p[2:0], bytes[k]});
            mreg[p] = bytes[k];
            if (inc) p = (p + 1) % 8;
            else     st = 3;
          end
          default: ;
        endcase
      end
      send_byte(bytes[k]);
    end
    for (int i = 0; i < partial_bits; i++) send_bit(1'b1);
    wait_clk(8);
  endtask

  task automatic end_frame();
    ser_csn = 1'b1;
    wait_clk(10);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 8; i++)
      check(reg_flat[i*8 +: 8] == mreg[i], req, reg_flat[i*8 +: 8], mreg[i]);
    check(expq.size() == 0, {req, " pending writes"}, expq.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    ser_csn = 1'b0;
    wait_clk(3);
    rst = 1'b0;
    wait_clk(4);
    // R1 reset state
    check(reg_flat == 64'd0, "R1 regs", reg_flat, 0);
    check(mode_latched == 1'b0, "R1 mode", mode_latched, 0);
    check(addr_err == 1'b0, "R1 err", addr_err, 0);
    check(wr_stb == 1'b0, "R1 stb", wr_stb, 0);

    // R2: chip select low since reset, no edge -> nothing written
    run_frame('{8'h20, 8'h01, 8'h55}, 0, 0);
    check(mode_latched == 1'b0, "R2 no edge", mode_latched, 0);
    check_regs("R2 no write before mode");
    end_frame();

    // R3 R5 R6: basic write, non-palindromic byte checks MSB first; pointer high bits ignored
    run_frame('{8'h20, 8'hFB, 8'h1E}, 0, 1);
    check(mode_latched == 1'b1, "R2 mode set", mode_latched, 1);
    end_frame();
    check(reg_flat[3*8 +: 8] == 8'h1E, "R3 msb first", reg_flat[3*8 +: 8], 8'h1E);
    check_regs("R5 pointer low bits");

    // R8: increment off, second data byte dropped
    run_frame('{8'h20, 8'h04, 8'h11, 8'h22}, 0, 1);
    end_frame();
    check_regs("R8 single write");

    // R4: bad chip byte
    run_frame('{8'h21, 8'h02, 8'h33}, 0, 1);
    check(addr_err == 1'b1, "R4 err set", addr_err, 1);
    end_frame();
    check_regs("R4 frame ignored");

    // R4 clear; set increment bit in register 0
    run_frame('{8'h20, 8'h00, 8'h80}, 0, 1);
    check(addr_err == 1'b0, "R4 err cleared", addr_err, 0);
    end_frame();
    check_regs("R6 reg0 write");

    // R7: burst wraps 7->0, clears steering bit; next byte lands, last dropped
    run_frame('{8'h20, 8'h06, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, 0, 1);
    end_frame();
    check(reg_flat[1*8 +: 8] == 8'h04, "R7 wrap then stop", reg_flat[1*8 +: 8], 8'h04);
    check_regs("R7 burst");

    // R9: abort mid-byte, earlier writes kept, next frame clean
    run_frame('{8'h20, 8'h02}, 5, 1);
    end_frame();
    check_regs("R9 abort keeps regs");
    run_frame('{8'h20, 8'h02, 8'h77}, 0, 1);
    end_frame();
    check_regs("R9 after abort");
    check(reg_flat[2*8 +: 8] == 8'h77, "R10 target reg", reg_flat[2*8 +: 8], 8'h77);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule